// File: doc/BRIEF.md
# Clock Output Bank Controller

This block sits between a clock input selector and one bank of clock output pairs. It takes the selected input clock and divides it by one, two or four. It then gates the result with an output enable and drives every pair of the bank with the same waveform. Each pair has a true pin and a complement pin. The configuration comes from three-level straps: one for the divider, two for the signal format, and one for the enable. Each strap is modelled as a two-bit code: `2'b00` is low, `2'b01` is high, and `2'b10` or `2'b11` is open.

The enable, and any change of the divider, take effect only on a falling edge of the input clock. They also take effect only at a point where the divided clock is low. As a result, no shortened high pulse ever reaches a pin. The format straps sort the bank into one of two classes, single-ended or differential. The class sets how the complement pin behaves. For a differential format it is the inverse of the true pin, and it idles high. For a single-ended format it repeats the true pin, and it idles low.

Top module: `clk_out_bank`

## Requirements
- R1: With the divider strap open (`2'b10` or `2'b11`) and the bank enabled, the true output follows the input clock. It is high exactly while the input clock is high.
- R2: With the divider strap low (`2'b00`) the output divides by 2. With it high (`2'b01`) the output divides by 4. In both cases the duty cycle is 50 %, and every high phase starts on a rising input edge.
- R3: A new divider code is adopted on a falling input edge at which the divided output is low. The new period starts with its high phase at the next rising edge. Across the change, every high pulse has the full width of the old ratio or the new ratio.
- R4: The enable is sampled on falling input edges. With the divider open, a change driven while the clock is high first shows on the rising edge that follows the next falling edge. That edge carries a full pulse when enabling and no pulse when disabling.
- R5: In the divided modes, enabling and disabling never produce a high pulse shorter than the divided high phase.
- R6: The enable code low (`2'b00`) disables the bank. High (`2'b01`), open (`2'b10`) and `2'b11` enable it.
- R7: When disabled in a differential format, every true output is 0 and every complement output is 1.
- R8: When disabled in a single-ended format, both outputs of every pair are 0.
- R9: The format straps, written as (first strap, second strap), select the single-ended class for (low, high), (high, low), (high, high) and (open, low). All other combinations select the differential class.
- R10: While enabled, a differential pair drives its complement as the inverse of the true output. A single-ended pair drives both pins with the same in-phase clock.
- R11: During reset all pairs show the disabled state for the current format. After reset the divider is in the open mode, and the first gate update happens on the first falling edge.
- R12: All pairs of the bank carry identical waveforms at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 2 | Divider strap code (low: /2, high: /4, open: /1) |
| fmt_hi_code | input | 2 | First format strap code |
| fmt_lo_code | input | 2 | Second format strap code |
| oe_code | input | 2 | Enable strap code (low disables) |
| q_t | output | N_PAIRS | True output of each pair |
| q_c | output | N_PAIRS | Complement output of each pair |

## Verification
A strap driven while the clock is high is sampled on the next falling edge. Its effect on the pins is due on the rising edge after that, or up to two clock periods later in the divide-by-4 mode while the divided clock is high. The bench samples 5 ns after every clock edge, so each sample lands in the middle of a clock half.

Exact-latency checks for R3, R4 and R11 wait for that falling edge and then that rising edge before they sample. The sweep over all 256 strap combinations first allows a settling window longer than the worst-case wait. Within the transition window it judges only complete high runs, measured in half-period samples, so a result does not depend on which cycle the change lands in.

// File: rtl/obc_pkg.sv
package obc_pkg;

   // three-level strap codes; bit 1 set means the pin is left open
   localparam logic [1:0] TRI_LOW  = 2'b00;
   localparam logic [1:0] TRI_HIGH = 2'b01;
   localparam logic [1:0] TRI_OPEN = 2'b10;

   typedef enum logic [1:0] {
      DM_BYPASS = 2'd0,
      DM_LO     = 2'd1,
      DM_HI     = 2'd2
   } div_mode_e;

   function automatic logic [1:0] tri_norm(input logic [1:0] code);
      return code[1] ? TRI_OPEN : code;
   endfunction

   function automatic div_mode_e div_decode(input logic [1:0] code);
      case (tri_norm(code))
         TRI_LOW:  return DM_LO;
         TRI_HIGH: return DM_HI;
         default:  return DM_BYPASS;
      endcase
   endfunction

   function automatic logic fmt_is_single(input logic [1:0] hi_code,
                                          input logic [1:0] lo_code);
      logic [3:0] pair;
      pair = {tri_norm(hi_code), tri_norm(lo_code)};
      case (pair)
         {TRI_LOW,  TRI_HIGH},
         {TRI_HIGH, TRI_LOW},
         {TRI_HIGH, TRI_HIGH},
         {TRI_OPEN, TRI_LOW}:  return 1'b1;
         default:              return 1'b0;
      endcase
   endfunction

   function automatic logic oe_active(input logic [1:0] code);
      return tri_norm(code) != TRI_LOW;
   endfunction

endpackage

// File: rtl/obc_strap_decode.sv
module obc_strap_decode
   import obc_pkg::*;
(
   input  logic [1:0] div_code_i,
   input  logic [1:0] fmt_hi_i,
   input  logic [1:0] fmt_lo_i,
   input  logic [1:0] oe_code_i,
   output div_mode_e  mode_o,
   output logic       single_o,
   output logic       en_o
);

   always_comb begin
      mode_o   = div_decode(div_code_i);
      single_o = fmt_is_single(fmt_hi_i, fmt_lo_i);
      en_o     = oe_active(oe_code_i);
   end

endmodule

// File: rtl/obc_divider.sv
module obc_divider
   import obc_pkg::*;
#(
   parameter int DIV_LO = 2,
   parameter int DIV_HI = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  div_mode_e mode_i,
   output logic      clk_div_o,
   output logic      quiet_o
);

   localparam int DIV_MAX = (DIV_LO > DIV_HI) ? DIV_LO : DIV_HI;
   localparam int PH_W    = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

   generate
      if (DIV_LO < 2 || (DIV_LO % 2) != 0) begin : g_bad_lo
         $error("DIV_LO must be an even ratio of at least 2");
      end
      if (DIV_HI < 2 || (DIV_HI % 2) != 0) begin : g_bad_hi
         $error("DIV_HI must be an even ratio of at least 2");
      end
   endgenerate

   div_mode_e       cur_q;
   logic            restart_q;
   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] ph_n;
   logic [PH_W-1:0] last_ph;
   logic [PH_W-1:0] half_ph;
   logic            div_q;

   assign quiet_o = (cur_q == DM_BYPASS) || !div_q;

   // configuration is adopted while the clock is low and the output is low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q     <= DM_BYPASS;
         restart_q <= 1'b0;
      end else if (mode_i != cur_q && quiet_o) begin
         cur_q     <= mode_i;
         restart_q <= 1'b1;
      end else begin
         restart_q <= 1'b0;
      end
   end

   always_comb begin
      case (cur_q)
         DM_LO: begin
            last_ph = PH_W'(DIV_LO - 1);
            half_ph = PH_W'(DIV_LO / 2);
         end
         DM_HI: begin
            last_ph = PH_W'(DIV_HI - 1);
            half_ph = PH_W'(DIV_HI / 2);
         end
         default: begin
            last_ph = '0;
            half_ph = '0;
         end
      endcase
      if (restart_q || ph_q >= last_ph) ph_n = '0;
      else                              ph_n = ph_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= '0;
         div_q <= 1'b0;
      end else if (cur_q == DM_BYPASS) begin
         ph_q  <= '0;
         div_q <= 1'b0;
      end else begin
         ph_q  <= ph_n;
         div_q <= (ph_n < half_ph);
      end
   end

   assign clk_div_o = (cur_q == DM_BYPASS) ? clk : div_q;

   // run length of the divided high phase, kept for the checks below
   logic [PH_W:0] hi_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              hi_run_q <= '0;
      else if (!div_q)         hi_run_q <= '0;
      else if (hi_run_q != '1) hi_run_q <= hi_run_q + 1'b1;
   end

   // R3
   div_swap_chk: assert property (@(negedge clk) disable iff (!rst_n)
      (cur_q != $past(cur_q)) |-> ($past(cur_q) == DM_BYPASS || !$past(div_q)));

   // R3
   restart_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restart_q && cur_q != DM_BYPASS) |=> div_q);

   // R2
   high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(hi_run_q) <= DIV_MAX / 2);

endmodule

// File: rtl/obc_enable_sync.sv
module obc_enable_sync #(
   parameter int SYNC_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic quiet_i,
   output logic gate_o
);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_stages
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic en_s;

   generate
      if (SYNC_STAGES == 1) begin : g_direct
         assign en_s = en_i;
      end else begin : g_chain
         localparam int PW = SYNC_STAGES - 1;
         logic [PW-1:0] pipe_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe_q <= '0;
            end else begin
               pipe_q[0] <= en_i;
               for (int k = 1; k < PW; k++) pipe_q[k] <= pipe_q[k-1];
            end
         end
         assign en_s = pipe_q[PW-1];
      end
   endgenerate

   logic gate_q;
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)       gate_q <= 1'b0;
      else if (quiet_i) gate_q <= en_s;
   end
   assign gate_o = gate_q;

   // R5
   gate_move_chk: assert property (@(negedge clk) disable iff (!rst_n)
      (gate_q != $past(gate_q)) |-> $past(quiet_i));

endmodule

// File: rtl/obc_pair_drive.sv
module obc_pair_drive (
   input  logic clk_div_i,
   input  logic gate_i,
   input  logic single_i,
   output logic q_t_o,
   output logic q_c_o
);

   logic live;
   assign live  = clk_div_i & gate_i;
   assign q_t_o = live;
   assign q_c_o = single_i ? live : ~live;

endmodule

// File: rtl/clk_out_bank.sv
module clk_out_bank
   import obc_pkg::*;
#(
   parameter int N_PAIRS        = 5,
   parameter int DIV_LO         = 2,
   parameter int DIV_HI         = 4,
   parameter int EN_SYNC_STAGES = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         div_code,
   input  logic [1:0]         fmt_hi_code,
   input  logic [1:0]         fmt_lo_code,
   input  logic [1:0]         oe_code,
   output logic [N_PAIRS-1:0] q_t,
   output logic [N_PAIRS-1:0] q_c
);

   generate
      if (N_PAIRS < 1) begin : g_bad_pairs
         $error("N_PAIRS must be at least 1");
      end
   endgenerate

   div_mode_e mode;
   logic      single;
   logic      en_req;
   logic      clk_div;
   logic      quiet;
   logic      gate;

   obc_strap_decode u_dec (
      .div_code_i (div_code),
      .fmt_hi_i   (fmt_hi_code),
      .fmt_lo_i   (fmt_lo_code),
      .oe_code_i  (oe_code),
      .mode_o     (mode),
      .single_o   (single),
      .en_o       (en_req)
   );

   obc_divider #(
      .DIV_LO (DIV_LO),
      .DIV_HI (DIV_HI)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (mode),
      .clk_div_o (clk_div),
      .quiet_o   (quiet)
   );

   obc_enable_sync #(
      .SYNC_STAGES (EN_SYNC_STAGES)
   ) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en_req),
      .quiet_i (quiet),
      .gate_o  (gate)
   );

   generate
      for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
         obc_pair_drive u_drv (
            .clk_div_i (clk_div),
            .gate_i    (gate),
            .single_i  (single),
            .q_t_o     (q_t[p]),
            .q_c_o     (q_c[p])
         );
      end
   endgenerate

   // R7
   diff_idle_chk: assert property (@(negedge clk) disable iff (!rst_n)
      (!gate && !single) |-> (q_t == '0 && q_c == '1));

   // R8
   single_idle_chk: assert property (@(negedge clk) disable iff (!rst_n)
      (!gate && single) |-> (q_t == '0 && q_c == '0));

   // R10
   single_phase_chk: assert property (@(negedge clk) disable iff (!rst_n)
      single |-> (q_c == q_t));

   // R10
   diff_phase_chk: assert property (@(negedge clk) disable iff (!rst_n)
      !single |-> (q_c == ~q_t));

   // R12
   pair_match_chk: assert property (@(negedge clk) disable iff (!rst_n)
      (q_t == {N_PAIRS{q_t[0]}}));

endmodule

// File: tb/test_clk_out_bank.sv
`timescale 1ns/1ps
module test_clk_out_bank;

   localparam int NP = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    div_code = 2'b10;
   logic [1:0]    fmt_hi_code = 2'b10;
   logic [1:0]    fmt_lo_code = 2'b10;
   logic [1:0]    oe_code = 2'b10;
   logic [NP-1:0] q_t;
   logic [NP-1:0] q_c;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   clk_out_bank #(
      .N_PAIRS        (NP),
      .DIV_LO         (2),
      .DIV_HI         (4),
      .EN_SYNC_STAGES (1)
   ) i_clk_out_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .div_code    (div_code),
      .fmt_hi_code (fmt_hi_code),
      .fmt_lo_code (fmt_lo_code),
      .oe_code     (oe_code),
      .q_t         (q_t),
      .q_c         (q_c)
   );

   // expected values, from the requirements
   function automatic int exp_ratio(input logic [1:0] c);
      if (c[1])      return 1;
      else if (c[0]) return 4;
      else           return 2;
   endfunction

   function automatic bit exp_single(input logic [1:0] h, input logic [1:0] l);
      int hv, lv;
      hv = h[1] ? 2 : int'(h);
      lv = l[1] ? 2 : int'(l);
      return (hv == 0 && lv == 1) || (hv == 1 && lv == 0) ||
             (hv == 1 && lv == 1) || (hv == 2 && lv == 0);
   endfunction

   function automatic bit exp_en(input logic [1:0] c);
      return c != 2'b00;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic drive_slot();
      @(posedge clk);
      #8;
   endtask

   bit samp [0:127];
   bit cmp_bad;
   bit pair_bad;

   // one sample 5 ns after each clock edge
   task automatic collect(input int n, input bit single);
      cmp_bad  = 0;
      pair_bad = 0;
      for (int i = 0; i < n; i++) begin
         @(clk);
         #5;
         samp[i] = q_t[0];
         if (q_t != {NP{q_t[0]}}) pair_bad = 1;
         if (single ? (q_c != q_t) : (q_c != ~q_t)) cmp_bad = 1;
      end
   endtask

   task automatic check_runs(input string req, input int n, input int ra,
                             input int rb, input bit chk_low);
      int  len;
      bit  seen;
      bit  bad;
      int  bad_len;
      len = 1; seen = 0; bad = 0; bad_len = 0;
      for (int i = 1; i < n; i++) begin
         if (samp[i] != samp[i-1]) begin
            if (seen) begin
               if (samp[i-1] && len != ra && len != rb) begin bad = 1; bad_len = len; end
               if (!samp[i-1] && chk_low && len != ra)  begin bad = 1; bad_len = len; end
            end
            seen = 1;
            len  = 1;
         end else begin
            len++;
         end
      end
      chk(!bad, req, "run length in half periods", bad_len, ra);
   endtask

   function automatic int ones(input int n);
      int s = 0;
      for (int i = 0; i < n; i++) s += int'(samp[i]);
      return s;
   endfunction

   initial begin
      #(20 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int rold;
      // reset state, differential class
      #5;
      chk(q_t == '0, "R11", "q_t in reset", q_t, 0);
      chk(q_c == '1, "R7", "q_c in reset (diff)", q_c, 31);
      fmt_hi_code = 2'b00; fmt_lo_code = 2'b01;
      #2;
      chk(q_c == '0, "R8", "q_c in reset (single)", q_c, 0);
      fmt_hi_code = 2'b10; fmt_lo_code = 2'b10;
      drive_slot();
      drive_slot();
      rst_n = 1'b1;
      @(negedge clk); #5;
      chk(q_t == '0, "R11", "q_t low phase after reset", q_t, 0);
      @(posedge clk); #5;
      chk(q_t == '1, "R11", "first pulse after reset", q_t, 31);

      // R4: disable and enable latency in bypass mode
      drive_slot();
      oe_code = 2'b00;
      @(negedge clk); @(posedge clk); #5;
      chk(q_t == '0, "R4", "pulse removed after disable", q_t, 0);
      chk(q_c == '1, "R7", "diff idle complement", q_c, 31);
      drive_slot();
      oe_code = 2'b11;
      @(negedge clk); @(posedge clk); #5;
      chk(q_t == '1, "R4", "pulse restored after enable (code 11, R6)", q_t, 31);

      // R3: switch from bypass to divide by 4, exact restart
      drive_slot();
      div_code = 2'b01;
      @(negedge clk); @(posedge clk); #5;
      samp[0] = q_t[0];
      for (int i = 1; i < 8; i++) begin
         @(clk); #5;
         samp[i] = q_t[0];
      end
      begin
         int pat;
         pat = 0;
         for (int i = 0; i < 8; i++) pat = (pat << 1) | int'(samp[i]);
         chk(pat == 8'hF0, "R3", "pattern after switch to /4", pat, 240);
      end

      // R1 R2 R3 R5 R6 R9 R10 R12: sweep over all strap combinations
      rold = 4;
      for (int o = 0; o < 4; o++) begin
         for (int d = 0; d < 4; d++) begin
            for (int h = 0; h < 4; h++) begin
               for (int l = 0; l < 4; l++) begin
                  bit sgl;
                  bit en;
                  int r;
                  drive_slot();
                  div_code    = 2'(d);
                  fmt_hi_code = 2'(h);
                  fmt_lo_code = 2'(l);
                  oe_code     = 2'(o);
                  sgl = exp_single(2'(h), 2'(l));
                  en  = exp_en(2'(o));
                  r   = exp_ratio(2'(d));
                  // transition window: no shortened pulse (R3, R5)
                  collect(20, sgl);
                  check_runs("R5", 20, rold, r, 1'b0);
                  collect(32, sgl);
                  chk(!cmp_bad, "R9", "complement class (R10)", cmp_bad, 0);
                  chk(!pair_bad, "R12", "pairs identical", pair_bad, 0);
                  if (en) begin
                     chk(ones(32) == 16, (r == 1) ? "R1" : "R2",
                         "high half periods in 32", ones(32), 16);
                     check_runs((r == 1) ? "R1" : "R2", 32, r, r, 1'b1);
                  end else begin
                     chk(ones(32) == 0, "R6", "disabled output (R7 R8)", ones(32), 0);
                  end
                  rold = en ? r : 1;
                  if (!en) rold = r;
               end
            end
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule